// File: doc/BRIEF.md
# Retriggerable Digital One-Shot

This block produces one clean, clock-counted pulse for each qualifying trigger event, the way an RC monostable would, but with every interval measured in cycles of the block clock. Three inputs can start a pulse: an active-low trigger, an active-high trigger and an active-low clear. Each input passes through a two-flop synchronizer and an edge detector, so all three may be driven from another clock domain or from a pin.

A pulse has two parts. A short fixed "discharge" interval of `DISCH_CYC` clocks comes first. A "charge" interval follows, and its length is the 16-bit width value captured when the trigger is taken. The pulse output is high for the whole of both parts. A trigger that arrives during the charge interval restarts the sequence, so the pulse is stretched without a gap. A trigger that arrives during the discharge interval is dropped. While clear is low, the output stays low and no trigger is taken. For two channels, place two instances.

Top module: `oneshot_top`

## Requirements
- R1: After reset, `pulse` is 0 and `pulse_n` is 1.
- R2: With `trg_lo_n` low, a rising edge on `trg_hi` starts a pulse. `pulse` rises at the third rising clock edge that samples the new input level.
- R3: With `trg_hi` high, a falling edge on `trg_lo_n` starts a pulse, with the same 3-clock latency.
- R4: With `trg_lo_n` low and `trg_hi` high, a rising edge on `clr_n` starts a pulse.
- R5: While the synchronized `clr_n` is low, `pulse` is 0 and edges on `trg_lo_n` and `trg_hi` start nothing. A falling `clr_n` drops `pulse` 3 clocks after the input edge.
- R6: A taken trigger keeps `pulse` high for exactly `DISCH_CYC` + W clocks. W is the value on `width` in the cycle the trigger is taken.
- R7: A `width` of 0 gives a charge interval of 1 clock, so the pulse lasts `DISCH_CYC` + 1 clocks.
- R8: A trigger taken during the charge interval restarts the discharge interval. `pulse` stays high without a gap and falls `DISCH_CYC` + W clocks after the new trigger.
- R9: A trigger that falls in the first `DISCH_CYC` clocks after a taken trigger has no effect on the pulse length.
- R10: `pulse_n` is always the inverse of `pulse`.
- R11: Edges that do not meet a trigger condition start nothing. These are a rising `trg_hi` while `trg_lo_n` is high, and a falling `trg_lo_n` while `trg_hi` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trg_lo_n | input | 1 | Active-low trigger; falling edge fires when trg_hi is high |
| trg_hi | input | 1 | Active-high trigger; rising edge fires when trg_lo_n is low |
| clr_n | input | 1 | Active-low clear; rising edge fires when both triggers are asserted |
| width | input | 16 | Charge interval in clocks, captured at each taken trigger (0 acts as 1) |
| pulse | output | 1 | One-shot output |
| pulse_n | output | 1 | Inverse of pulse |

## Verification
A wrong phase or count shows at the ports as a pulse that is too short or too long. It can also show as a gap where a retrigger should have stretched the pulse, or as a stretch where a trigger during discharge should have been dropped. In every case the error is visible on `pulse` within `DISCH_CYC` + W clocks of the trigger that caused it. A wrong synchronizer or edge-detector stage shows as a shift in the 3-clock rise latency. It can also show as a trigger that fires on the wrong polarity, which produces a pulse from idle within three clocks. The bench compares `pulse` and `pulse_n` against a cycle model every clock, so any such error is reported in the cycle it first appears.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DISCH  = 2'd1,
    ST_CHARGE = 2'd2
  } os_state_e;

  // charge length actually used: a zero request counts as one clock
  function automatic logic [31:0] eff_width(input logic [31:0] w);
    return (w == 32'd0) ? 32'd1 : w;
  endfunction

  // trigger qualification from current and previous synchronized levels
  function automatic logic fire(input logic lo_n, input logic lo_n_prev,
                                input logic hi, input logic hi_prev,
                                input logic clr, input logic clr_prev);
    logic armed;
    armed = ~lo_n & hi;
    return clr & ((armed & ~hi_prev) | (armed & lo_n_prev) | (armed & ~clr_prev));
  endfunction

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int N_BITS = 3,
  parameter int STAGES = 2,
  parameter logic [N_BITS-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BITS-1:0] d,
  output logic [N_BITS-1:0] q
);
  logic [N_BITS-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/oneshot_trig.sv
module oneshot_trig
  import oneshot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lo_n_s,
  input  logic hi_s,
  input  logic clr_s,
  output logic trig_hit,
  output logic clr_lvl
);
  logic lo_n_d, hi_d, clr_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_n_d <= 1'b1;
      hi_d   <= 1'b0;
      clr_d  <= 1'b1;
    end else begin
      lo_n_d <= lo_n_s;
      hi_d   <= hi_s;
      clr_d  <= clr_s;
    end

  assign trig_hit = fire(lo_n_s, lo_n_d, hi_s, hi_d, clr_s, clr_d);
  assign clr_lvl  = clr_s;

  // a trigger needs an edge: unchanged levels never fire
  AST_TRIG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_n_s == lo_n_d && hi_s == hi_d && clr_s == clr_d) |-> !trig_hit); // R11
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int W_BITS    = 16,
  parameter int DISCH_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_hit,
  input  logic              clr_lvl,
  input  logic [W_BITS-1:0] width,
  output logic              busy,
  output os_state_e         st
);
  localparam int D_BITS = $clog2(DISCH_CYC + 1);
  localparam int CNT_W  = (W_BITS > D_BITS) ? W_BITS : D_BITS;
  localparam logic [CNT_W-1:0] D_LAST = CNT_W'(DISCH_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] width_q;
  logic [CNT_W-1:0] width_eff;
  logic             trig_acc;
  logic             cnt_zero;

  assign width_eff = CNT_W'(eff_width(32'(width)));
  assign trig_acc  = trig_hit && (st != ST_DISCH);
  assign cnt_zero  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      width_q <= CNT_W'(1);
    end else if (!clr_lvl) begin
      st      <= ST_IDLE;
      cnt     <= '0;
    end else if (trig_acc) begin
      st      <= ST_DISCH;
      cnt     <= D_LAST;
      width_q <= width_eff;
    end else begin
      unique case (st)
        ST_DISCH: begin
          if (cnt_zero) begin
            st  <= ST_CHARGE;
            cnt <= width_q - CNT_W'(1);
          end else cnt <= cnt - CNT_W'(1);
        end
        ST_CHARGE: begin
          if (cnt_zero) st <= ST_IDLE;
          else          cnt <= cnt - CNT_W'(1);
        end
        default: cnt <= '0;
      endcase
    end

  assign busy = (st != ST_IDLE);

  AST_CLR_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_lvl |=> (st == ST_IDLE)); // R5
  AST_ACCEPT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lvl && trig_hit && st != ST_DISCH) |=> (st == ST_DISCH && cnt == D_LAST)); // R8
  AST_DISCH_DROPS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lvl && st == ST_DISCH && !cnt_zero) |=> (st == ST_DISCH && cnt == $past(cnt) - CNT_W'(1))); // R9
  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig_hit)); // R2
  AST_CHARGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHARGE) |-> (cnt < width_q)); // R7
  AST_FALL_AFTER_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(st) == ST_CHARGE || !$past(clr_lvl))); // R6
endmodule

// File: rtl/oneshot_top.sv
module oneshot_top
  import oneshot_pkg::*;
#(
  parameter int W_BITS    = 16,
  parameter int DISCH_CYC = 2,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trg_lo_n,
  input  logic              trg_hi,
  input  logic              clr_n,
  input  logic [W_BITS-1:0] width,
  output logic              pulse,
  output logic              pulse_n
);
  localparam logic [2:0] IN_IDLE = 3'b101; // {lo_n, hi, clr}

  logic [2:0] raw_in, sync_in;
  logic       trig_hit, clr_lvl, busy;
  os_state_e  st;

  assign raw_in = {trg_lo_n, trg_hi, clr_n};

  oneshot_sync #(.N_BITS(3), .STAGES(SYNC_STG), .RST_VAL(IN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
  );

  oneshot_trig u_trig (
    .clk(clk), .rst_n(rst_n),
    .lo_n_s(sync_in[2]), .hi_s(sync_in[1]), .clr_s(sync_in[0]),
    .trig_hit(trig_hit), .clr_lvl(clr_lvl)
  );

  oneshot_timer #(.W_BITS(W_BITS), .DISCH_CYC(DISCH_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .trig_hit(trig_hit), .clr_lvl(clr_lvl),
    .width(width), .busy(busy), .st(st)
  );

  assign pulse   = busy;
  assign pulse_n = ~busy;

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    st != 2'd3); // R6
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!pulse && pulse_n)); // R10
endmodule

// File: tb/sim_oneshot_top.sv
module sim_oneshot_top;
  localparam int D = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_n = 1'b1, hi = 1'b0, clr = 1'b1;
  logic [15:0] width = 16'd4;
  logic pulse, pulse_n;

  int vecs = 0, bad = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  oneshot_top #(.W_BITS(16), .DISCH_CYC(D), .SYNC_STG(2)) u0 (
    .clk(clk), .rst_n(rst_n), .trg_lo_n(lo_n), .trg_hi(hi), .clr_n(clr),
    .width(width), .pulse(pulse), .pulse_n(pulse_n)
  );

  function automatic int unsigned span(input logic [15:0] w);
    return D + ((w == 16'd0) ? 1 : int'(w));
  endfunction

  // qualifying condition restated in terms of levels one clock apart
  function automatic bit qualifies(input logic [2:0] now, input logic [2:0] was);
    bit lo_act = !now[2], hi_act = now[1], clr_ok = now[0];
    if (!(lo_act && hi_act && clr_ok)) return 0;
    return (!was[1]) || was[2] || (!was[0]);
  endfunction

  logic [2:0] hx [4];
  int unsigned rem = 0, guard = 0;
  bit exp_q = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) hx[i] = 3'b101;
      rem = 0; guard = 0;
    end else begin
      hx[3] = hx[2]; hx[2] = hx[1]; hx[1] = hx[0]; hx[0] = {lo_n, hi, clr};
      if (!hx[2][0]) begin
        rem = 0; guard = 0;
      end else if (qualifies(hx[2], hx[3]) && guard == 0) begin
        rem = span(width); guard = D;
      end else begin
        if (rem > 0) rem--;
        if (guard > 0) guard--;
      end
    end
    exp_q = (rem > 0);
  end

  task automatic check(input string t, input bit act, input bit expv);
    vecs++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", t, act, expv, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check({tag, " R10 pulse"}, pulse, exp_q);
    check("R10 pulse_n", pulse_n, ~exp_q);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hung expected finish");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin : main
    idle(3);
    check("R1 reset pulse", pulse, 1'b0);
    check("R1 reset pulse_n", pulse_n, 1'b1);
    rst_n = 1'b1;
    idle(4);

    tag = "R11";                      // lo_n falls while hi low: no fire
    lo_n = 1'b0; idle(6);
    check("R11 no fire", pulse, 1'b0);

    tag = "R2"; width = 16'd5;        // hi rises with lo_n low
    hi = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 latency low", pulse, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R2 latency high", pulse, 1'b1);
    idle(span(16'd5) + 2);
    check("R6 ended", pulse, 1'b0);

    tag = "R11";                      // hi rises while lo_n high: no fire
    lo_n = 1'b1; hi = 1'b0; idle(4);
    hi = 1'b1; idle(6);
    check("R11 no fire hi", pulse, 1'b0);

    tag = "R3"; width = 16'd3;        // lo_n falls with hi high
    lo_n = 1'b0; idle(4);
    check("R3 fired", pulse, 1'b1);
    idle(span(16'd3) + 2);

    tag = "R4"; clr = 1'b0; idle(5);  // clr rise with both armed
    clr = 1'b1; idle(4);
    check("R4 fired", pulse, 1'b1);
    idle(span(16'd3) + 2);

    tag = "R7"; width = 16'd0; hi = 1'b0; idle(4);
    hi = 1'b1; idle(3);
    check("R7 width0 high", pulse, 1'b1);
    idle(span(16'd0));
    check("R7 width0 ended", pulse, 1'b0);

    tag = "R9"; width = 16'd6; hi = 1'b0; idle(4);
    hi = 1'b1; idle(1); hi = 1'b0; idle(1); hi = 1'b1; idle(3);
    idle(span(16'd6) - 1);
    check("R9 not stretched", pulse, 1'b0);

    tag = "R8"; hi = 1'b0; idle(4);
    hi = 1'b1; idle(3 + D + 2); hi = 1'b0; idle(2); hi = 1'b1; idle(3);
    check("R8 still high", pulse, 1'b1);
    idle(span(16'd6) + 1);
    check("R8 ended", pulse, 1'b0);

    tag = "R5"; hi = 1'b0; idle(4);
    hi = 1'b1; idle(5); clr = 1'b0; idle(3);
    check("R5 forced low", pulse, 1'b0);
    hi = 1'b0; idle(2); hi = 1'b1; idle(5);
    check("R5 ignored", pulse, 1'b0);
    lo_n = 1'b1; clr = 1'b1; idle(5);

    tag = "R6 R8 R9 random";
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      lo_n  = ($urandom % 4) == 0;
      hi    = ($urandom % 3) != 0 ? ~hi : hi;
      clr   = ($urandom % 40) != 0;
      width = 16'($urandom % 12);
      idle(1 + ($urandom % 6));
    end
    lo_n = 1'b1; hi = 1'b0; clr = 1'b1;
    idle(40);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule